// File: doc/BRIEF.md
# System Counter with Compare Interrupt

This block keeps a free-running 64-bit time base and pairs it with one compare channel that can raise a level interrupt. The count advances only on cycles where the count-clock enable input is high. By default an internal prescaler lets one count step through for every three enabled cycles. A strap input bypasses that prescaler so that every enabled cycle advances the count.

Software reaches the block through single-cycle 32-bit register accesses. It reads the count as a low word and a high word, which are also mirrored in a second read window. It programs a compare value of up to 52 bits. It controls the channel with an enable bit and a mask bit, and it reads a sticky status bit.

The only way to clear the status bit is to write the enable bit to 0. A driver therefore acknowledges an interrupt by disabling the channel, then reprograms the compare value and enables it again.

Top module: `sctr_top`

## Requirements
- R1: After a synchronous reset the count equals the INIT_COUNT parameter (default 0), the compare low word reads 0xFFFFFFFF, the compare high word reads 0x000FFFFF, the control register reads 0, and irq is 0.
- R2: With the bypass strap at 0, the count increments by one on every third cycle with cnt_en high, counting from reset. Cycles with cnt_en low change neither the count nor the prescaler phase.
- R3: With the bypass strap at 1, the count increments by one on every cycle with cnt_en high.
- R4: A read returns data on rdata in the cycle after the address is presented. The count low word is at 0x00008 and the high word at 0x0000C. The same count is mirrored at 0x20008 (low) and 0x2000C (high). Any unmapped address reads 0.
- R5: The compare low word at 0x10020 reads back as written. The compare high word at 0x10024 keeps only bits [19:0]; bits [31:20] are ignored on write and read as 0.
- R6: In the control register at 0x1002C, bit 0 is enable, bit 1 is mask, and bit 2 returns status and ignores writes. Bits [31:3] read back what was last written.
- R7: While enable is 1, status becomes 1 at the first count increment after which the count is greater than or equal to the 64-bit zero-extended compare value. Status stays 1 until enable is written 0, and that write clears status in the same clock. An enable write alone, with no increment, never sets status.
- R8: irq equals status AND enable AND NOT mask, and it changes on the same clock edge as the status and control state.
- R9: The count high word changes only on the increment that wraps the low word from 0xFFFFFFFF to 0.
- R10: A compare write made while enable is 1 takes effect at once: the next increment is compared against the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable; one prescaler step per high cycle |
| div_bypass | input | 1 | Strap: 1 makes every enabled cycle advance the count |
| addr | input | 18 | Register byte address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Level interrupt |

## Verification
A prescaler phase that slips shows up as a count word off by one within three enabled cycles. It is caught by the bench sweep, which reads the count after every single enabled cycle. A status bit that is set or cleared at the wrong time shows on irq at the very next sampling point. The bench watches irq one increment before the threshold and one increment after it, and again after each mask and enable write. Errors in the wrap carry or in the high-word field width only show in specific register reads. These are checked at the wrap of a second instance that is preset just below 2^32, and by reading back the compare words.

// File: rtl/sctr_pkg.sv
package sctr_pkg;
  localparam int ADDR_W = 18;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 18'h00008;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 18'h0000C;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 18'h10020;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 18'h10024;
  localparam logic [ADDR_W-1:0] A_CTRL    = 18'h1002C;
  localparam logic [ADDR_W-1:0] A_MIR_LO  = 18'h20008;
  localparam logic [ADDR_W-1:0] A_MIR_HI  = 18'h2000C;

  typedef struct packed {
    logic [DATA_W-4:0] spare;
    logic              mask;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/sctr_prescale.sv
module sctr_prescale #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cnt_en,
  input  logic bypass,
  output logic tick
);
  generate
    if (DIV > 1) begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk) begin
        if (rst) begin
          phase <= '0;
        end else if (cnt_en && !bypass) begin
          if (phase == LAST) phase <= '0;
          else               phase <= phase + 1'b1;
        end
      end

      assign tick = cnt_en && (bypass || (phase == LAST));
    end else begin : g_nodiv
      logic unused_bypass;
      assign unused_bypass = bypass;
      assign tick = cnt_en;
    end
  endgenerate
endmodule

// File: rtl/sctr_count.sv
module sctr_count #(
  parameter int          CNT_W = 64,
  parameter logic [63:0] INIT  = 64'd0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= INIT[CNT_W-1:0];
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sctr_cmp.sv
module sctr_cmp
  import sctr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int HI_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmp_lo,
  output logic [HI_W-1:0]   cmp_hi,
  output ctrl_t             ctrl,
  output logic              status,
  output logic              irq
);
  localparam int PAD_W = CNT_W - DATA_W - HI_W;

  logic [CNT_W-1:0] cmp_full;
  logic [CNT_W-1:0] cnt_next;
  logic             hit;
  ctrl_t            ctrl_n;
  logic             status_n;

  assign cmp_full = {{PAD_W{1'b0}}, cmp_hi, cmp_lo};
  assign cnt_next = cnt + 1'b1;
  assign hit      = tick && ctrl.en && (cnt_next >= cmp_full);

  always_comb begin
    ctrl_n = ctrl;
    if (wr_ctrl) begin
      ctrl_n.en    = wdata[0];
      ctrl_n.mask  = wdata[1];
      ctrl_n.spare = wdata[DATA_W-1:3];
    end
    if (!ctrl_n.en)  status_n = 1'b0;
    else if (hit)    status_n = 1'b1;
    else             status_n = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_lo <= '1;
      cmp_hi <= '1;
      ctrl   <= '0;
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_lo) cmp_lo <= wdata;
      if (wr_hi) cmp_hi <= wdata[HI_W-1:0];
      ctrl   <= ctrl_n;
      status <= status_n;
      irq    <= status_n && ctrl_n.en && !ctrl_n.mask;
    end
  end
endmodule

// File: rtl/sctr_top.sv
module sctr_top
  import sctr_pkg::*;
#(
  parameter int          CNT_W      = 64,
  parameter int          HI_W       = 20,
  parameter int          DIV        = 3,
  parameter logic [63:0] INIT_COUNT = 64'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              div_bypass,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int HI_PAD = DATA_W - HI_W;

  logic              tick;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] cmp_lo;
  logic [HI_W-1:0]   cmp_hi;
  ctrl_t             ctrl;
  logic              status;
  logic [DATA_W-1:0] rd_mux;

  sctr_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .bypass(div_bypass), .tick(tick)
  );

  sctr_count #(.CNT_W(CNT_W), .INIT(INIT_COUNT)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt)
  );

  sctr_cmp #(.CNT_W(CNT_W), .HI_W(HI_W)) u_cmp (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt),
    .wr_lo(wr_en && (addr == A_CMP_LO)),
    .wr_hi(wr_en && (addr == A_CMP_HI)),
    .wr_ctrl(wr_en && (addr == A_CTRL)),
    .wdata(wdata), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .ctrl(ctrl), .status(status), .irq(irq)
  );

  always_comb begin
    unique case (addr)
      A_CNT_LO, A_MIR_LO: rd_mux = cnt[DATA_W-1:0];
      A_CNT_HI, A_MIR_HI: rd_mux = cnt[CNT_W-1:DATA_W];
      A_CMP_LO:           rd_mux = cmp_lo;
      A_CMP_HI:           rd_mux = {{HI_PAD{1'b0}}, cmp_hi};
      A_CTRL:             rd_mux = {ctrl.spare, status, ctrl.mask, ctrl.en};
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/sctr_chk.sv
module sctr_chk (
  input logic        clk,
  input logic        rst,
  input logic        div_bypass,
  input logic        tick,
  input logic [63:0] cnt,
  input logic        status,
  input logic        en,
  input logic        mask,
  input logic        irq
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + 64'd1)); // R3

  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
    ($past(tick) && !div_bypass && $past(!div_bypass)) |-> !tick); // R2

  AST_HI_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt[63:32] != $past(cnt[63:32])) |-> ($past(cnt[31:0]) == 32'hFFFFFFFF)); // R9

  AST_OFF_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
    !en |-> !status); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(status) && en) |-> status); // R7

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq == (status && en && !mask)); // R8
endmodule

bind sctr_top sctr_chk u_chk (
  .clk(clk), .rst(rst), .div_bypass(div_bypass), .tick(tick),
  .cnt(cnt), .status(status), .en(ctrl.en), .mask(ctrl.mask), .irq(irq)
);

// File: tb/sctr_top_test.sv
module sctr_top_test;
  localparam int PERIOD = 10;
  localparam logic [63:0] W_INIT = 64'h0000_0000_FFFF_FFFD;

  logic        clk = 0;
  logic        rst = 1;
  logic        cnt_en = 0;
  logic        div_bypass = 0;
  logic [17:0] addr = '0;
  logic        wr_en = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, w_rdata;
  logic        irq, w_irq;

  int checks = 0;
  int errors = 0;
  int ecyc = 0;

  always #(PERIOD/2) clk = ~clk;

  sctr_top uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .div_bypass(div_bypass),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  sctr_top #(.INIT_COUNT(W_INIT)) uut_wrap (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .div_bypass(1'b1),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(w_rdata), .irq(w_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic byp);
    @(negedge clk);
    rst = 1; div_bypass = byp; cnt_en = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    ecyc = 0;
  endtask

  task automatic rd(input logic [17:0] a, output logic [31:0] d, output logic [31:0] dw);
    @(negedge clk);
    addr = a; wr_en = 0;
    @(negedge clk);
    d = rdata; dw = w_rdata;
  endtask

  task automatic wr(input logic [17:0] a, input logic [31:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    cnt_en = 1;
    repeat (n) @(negedge clk);
    cnt_en = 0;
    ecyc += n;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, dw, d2, dw2;

    // reset state
    do_reset(1'b0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(18'h00008, d, dw); check("R1 cnt lo", d, 32'd0);
    check("R1 wrap init lo", dw, 32'hFFFF_FFFD);
    rd(18'h0000C, d, dw); check("R1 cnt hi", d, 32'd0);
    rd(18'h10020, d, dw); check("R1 cmp lo", d, 32'hFFFF_FFFF);
    rd(18'h10024, d, dw); check("R1 cmp hi", d, 32'h000F_FFFF);
    rd(18'h1002C, d, dw); check("R1 ctrl", d, 32'd0);
    rd(18'h00004, d, dw); check("R4 unmapped", d, 32'd0);

    // wrap of low word on the preset instance (bypass strapped)
    wr(18'h10024, 32'd1);
    wr(18'h10020, 32'd0);
    wr(18'h1002C, 32'd1);
    run(2);
    check("R7 wrap no hit before", {31'd0, w_irq}, 32'd0);
    rd(18'h00008, d, dw); check("R9 lo before wrap", dw, 32'hFFFF_FFFF);
    rd(18'h0000C, d, dw); check("R9 hi before wrap", dw, 32'd0);
    run(1);
    check("R7 hit on high word", {31'd0, w_irq}, 32'd1);
    check("R7 div3 instance no hit", {31'd0, irq}, 32'd0);
    rd(18'h00008, d, dw); check("R9 lo after wrap", dw, 32'd0);
    rd(18'h0000C, d, dw); check("R9 hi after wrap", dw, 32'd1);
    rd(18'h2000C, d, dw); check("R4 mirror hi", dw, 32'd1);
    rd(18'h00008, d, dw); check("R2 div3 after 3", d, 32'd1);

    // divide-by-3 sweep
    do_reset(1'b0);
    for (int i = 1; i <= 12; i++) begin
      run(1);
      rd(18'h00008, d, dw);
      check("R2 div3 count", d, 32'(ecyc / 3));
      rd(18'h20008, d2, dw2);
      check("R4 mirror lo", d2, 32'(ecyc / 3));
    end
    repeat (7) @(negedge clk);
    rd(18'h00008, d, dw); check("R2 hold while cnt_en low", d, 32'(ecyc / 3));

    // bypass mode
    do_reset(1'b1);
    for (int i = 1; i <= 5; i++) begin
      run(1);
      rd(18'h00008, d, dw); check("R3 bypass count", d, 32'(ecyc));
    end
    wr(18'h10024, 32'hFFF0_0000);
    rd(18'h10024, d, dw); check("R5 cmp hi upper ignored", d, 32'd0);
    wr(18'h10020, 32'd10);
    rd(18'h10020, d, dw); check("R5 cmp lo", d, 32'd10);
    wr(18'h1002C, 32'd1);
    run(4);
    check("R7 below threshold", {31'd0, irq}, 32'd0);
    run(1);
    check("R7 at threshold", {31'd0, irq}, 32'd1);
    rd(18'h1002C, d, dw); check("R6 status bit", d, 32'd5);
    run(3);
    check("R7 sticky", {31'd0, irq}, 32'd1);
    wr(18'h1002C, 32'd3);
    check("R8 masked", {31'd0, irq}, 32'd0);
    rd(18'h1002C, d, dw); check("R8 status kept under mask", d, 32'd7);
    wr(18'h1002C, 32'd1);
    check("R8 unmasked", {31'd0, irq}, 32'd1);
    wr(18'h1002C, 32'd0);
    check("R7 clear by enable", {31'd0, irq}, 32'd0);
    rd(18'h1002C, d, dw); check("R7 status cleared", d, 32'd0);
    wr(18'h1002C, 32'd1);
    repeat (2) @(negedge clk);
    check("R7 enable alone no set", {31'd0, irq}, 32'd0);
    run(1);
    check("R7 set on increment past", {31'd0, irq}, 32'd1);
    wr(18'h1002C, 32'd0);

    // compare rewrite while enabled
    wr(18'h10020, 32'd100);
    wr(18'h1002C, 32'd1);
    run(2);
    check("R10 far compare", {31'd0, irq}, 32'd0);
    wr(18'h10020, 32'(ecyc + 1));
    run(1);
    check("R10 new compare used", {31'd0, irq}, 32'd1);

    // control readback
    wr(18'h1002C, 32'hA5A5_A5FE);
    rd(18'h1002C, d, dw); check("R6 ctrl readback", d, 32'hA5A5_A5FA);
    check("R6 irq off when disabled", {31'd0, irq}, 32'd0);

    // high compare word counts
    wr(18'h1002C, 32'd0);
    wr(18'h10020, 32'd0);
    wr(18'h10024, 32'd1);
    wr(18'h1002C, 32'd1);
    run(5);
    check("R5 high word compared", {31'd0, irq}, 32'd0);
    rd(18'h0000C, d, dw); check("R9 hi stays", d, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule